// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Collector

This block is the landing point for inbound message-signalled interrupt writes. Each write names a group and an index register through its address offset, and a vector bit through its data value. The block sets that bit and holds it as pending until software reads the index register, which returns the pending bits and clears them in the same access. There are 16 groups of 8 index registers, each 16 bits wide, for 2048 vectors in all.

Each group also has a read-only summary register with one bit per index register that holds any pending vector. Each group drives one level interrupt line, which stays high while anything in the group is pending. A handler reads the summary, then reads and clears the flagged index registers. Malformed writes are dropped and counted.

Top module: `msi_term_collector`

## Requirements
- R1: A write with `wr_valid` high, offset bit 23 zero, offset bits [15:0] zero and data d in 0..15 sets bit d of index register x (offset bits [18:16]) in group g (offset bits [22:19]). Bits already set stay set.
- R2: A read of an index register puts its contents on `rd_data` one cycle after `rd_en`, and clears every bit of that register in the same edge.
- R3: The summary register of group g sits at offset 0x800000 + g*0x10000. Its bit x is 1 exactly when index register x of group g holds a set bit, and bits 15..8 read as zero.
- R4: `irq[g]` is high while any index register of group g holds a set bit. It stays high until every such register has been read clear.
- R5: When a valid write and a read hit the same index register in the same cycle, the read returns the contents from before the write. The written bit remains pending afterwards.
- R6: Reading a summary register changes no pending state.
- R7: A read of an offset that is neither an index nor a summary register returns zero and changes no pending state.
- R8: A write with data above 15, or to an offset outside the index-register region, changes no pending state. It increments `err_cnt` by one, and the count saturates at all ones.
- R9: After reset every index register is clear, all `irq` lines are low and `err_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Termination write strobe |
| wr_addr | input | 24 | Termination write byte offset |
| wr_data | input | 32 | Termination write data (vector bit number) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read byte offset |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |
| irq | output | 16 | Level interrupt, one per group |
| err_cnt | output | 16 | Saturating count of rejected writes |

## Verification
A termination write and a read-to-clear can land on the same index register in one cycle. The bench provokes this by driving both strobes in one cycle, first onto a register that already holds one bit, then onto an empty one. The scoreboard expects the read to return only the earlier contents. A second read must then show only the bit that was written alongside the first read, with the group interrupt still high in between.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_INDEX = 2'd1,
    RGN_SUM   = 2'd2
  } region_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int NUM_GRP = 16,
  parameter int NUM_IDX = 8,
  parameter int ADDR_W  = 24,
  parameter int IDX_LSB = 16
) (
  input  logic [ADDR_W-1:0]          addr,
  output region_e                    region,
  output logic [$clog2(NUM_GRP)-1:0] grp,
  output logic [$clog2(NUM_IDX)-1:0] idx
);
  localparam int GRP_W   = $clog2(NUM_GRP);
  localparam int IDX_W   = $clog2(NUM_IDX);
  localparam int GRP_LSB = IDX_LSB + IDX_W;
  localparam logic [ADDR_W-1:0] SUM_BASE = ADDR_W'(1) << (ADDR_W - 1);

  function automatic logic in_index(input logic [ADDR_W-1:0] a);
    return ((a >> (GRP_LSB + GRP_W)) == '0) && (a[IDX_LSB-1:0] == '0);
  endfunction

  function automatic logic in_summary(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    rel = a - SUM_BASE;
    return (a >= SUM_BASE) && (a[IDX_LSB-1:0] == '0) &&
           ((rel >> IDX_LSB) < ADDR_W'(NUM_GRP));
  endfunction

  always_comb begin
    region = RGN_NONE;
    grp    = '0;
    idx    = '0;
    if (in_index(addr)) begin
      region = RGN_INDEX;
      grp    = addr[GRP_LSB +: GRP_W];
      idx    = addr[IDX_LSB +: IDX_W];
    end else if (in_summary(addr)) begin
      region = RGN_SUM;
      grp    = addr[IDX_LSB +: GRP_W];
    end
  end
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank #(
  parameter int NUM_IDX = 8,
  parameter int VEC_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [$clog2(NUM_IDX)-1:0] set_idx,
  input  logic [$clog2(VEC_W)-1:0]   set_bit,
  input  logic                       clr_en,
  input  logic [$clog2(NUM_IDX)-1:0] clr_idx,
  output logic [NUM_IDX*VEC_W-1:0]   regs,
  output logic [NUM_IDX-1:0]         summary
);
  localparam int IDX_W = $clog2(NUM_IDX);

  function automatic logic [VEC_W-1:0] next_val(
    input logic [VEC_W-1:0]         cur,
    input logic                     clr,
    input logic                     set,
    input logic [$clog2(VEC_W)-1:0] bitn
  );
    logic [VEC_W-1:0] v;
    v = clr ? '0 : cur;
    if (set) v = v | (VEC_W'(1) << bitn);
    return v;
  endfunction

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) regs[i*VEC_W +: VEC_W] <= '0;
      else        regs[i*VEC_W +: VEC_W] <= next_val(regs[i*VEC_W +: VEC_W], hit_clr, hit_set, set_bit);
    end
    assign summary[i] = |regs[i*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/msi_term_collector.sv
module msi_term_collector
  import msi_term_pkg::*;
#(
  parameter int NUM_GRP = 16,
  parameter int NUM_IDX = 8,
  parameter int VEC_W   = 16,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int ERR_W   = 16,
  parameter int IDX_LSB = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [VEC_W-1:0]   rd_data,
  output logic [NUM_GRP-1:0] irq,
  output logic [ERR_W-1:0]   err_cnt
);
  localparam int GRP_W = $clog2(NUM_GRP);
  localparam int IDX_W = $clog2(NUM_IDX);
  localparam int BIT_W = $clog2(VEC_W);

  region_e            w_rgn, r_rgn;
  logic [GRP_W-1:0]   w_grp, r_grp;
  logic [IDX_W-1:0]   w_idx, r_idx;

  msi_addr_decode #(.NUM_GRP(NUM_GRP), .NUM_IDX(NUM_IDX), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB))
    u_wdec (.addr(wr_addr), .region(w_rgn), .grp(w_grp), .idx(w_idx));
  msi_addr_decode #(.NUM_GRP(NUM_GRP), .NUM_IDX(NUM_IDX), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB))
    u_rdec (.addr(rd_addr), .region(r_rgn), .grp(r_grp), .idx(r_idx));

  // Named events for the checker
  logic wr_ok, wr_bad, rd_clr, rd_is_sum, rd_unmapped;
  assign wr_ok       = wr_valid && (w_rgn == RGN_INDEX) && (wr_data < DATA_W'(VEC_W));
  assign wr_bad      = wr_valid && !wr_ok;
  assign rd_clr      = rd_en && (r_rgn == RGN_INDEX);
  assign rd_is_sum   = (r_rgn == RGN_SUM);
  assign rd_unmapped = (r_rgn == RGN_NONE);

  logic [NUM_IDX*VEC_W-1:0] bank_regs [NUM_GRP];
  logic [NUM_IDX-1:0]       bank_sum  [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    msi_group_bank #(.NUM_IDX(NUM_IDX), .VEC_W(VEC_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr_ok && (w_grp == GRP_W'(g))),
      .set_idx (w_idx),
      .set_bit (wr_data[BIT_W-1:0]),
      .clr_en  (rd_clr && (r_grp == GRP_W'(g))),
      .clr_idx (r_idx),
      .regs    (bank_regs[g]),
      .summary (bank_sum[g])
    );
    assign irq[g] = |bank_sum[g];
  end

  logic [VEC_W-1:0] rd_next;
  always_comb begin
    unique case (r_rgn)
      RGN_INDEX: rd_next = bank_regs[r_grp][r_idx*VEC_W +: VEC_W];
      RGN_SUM:   rd_next = VEC_W'(bank_sum[r_grp]);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       err_cnt <= '0;
    else if (wr_bad && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
  end
endmodule

// File: rtl/msi_term_chk.sv
module msi_term_chk #(
  parameter int NUM_GRP = 16,
  parameter int VEC_W   = 16,
  parameter int ERR_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [VEC_W-1:0]   rd_data,
  input logic [NUM_GRP-1:0] irq,
  input logic [ERR_W-1:0]   err_cnt,
  input logic               wr_ok,
  input logic               wr_bad,
  input logic               rd_is_sum,
  input logic               rd_unmapped
);
  a_r8_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad && (err_cnt != '1) |=> err_cnt == ERR_W'($past(err_cnt) + 1'b1));

  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bad |=> $stable(err_cnt));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_unmapped |=> rd_data == '0);

  a_r6_sum_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_is_sum && !wr_ok |=> $stable(irq));

  a_r4_irq_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(irq)) != '0 |-> $past(wr_ok));
endmodule

bind msi_term_collector msi_term_chk #(.NUM_GRP(NUM_GRP), .VEC_W(VEC_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
  .err_cnt(err_cnt), .wr_ok(wr_ok), .wr_bad(wr_bad), .rd_is_sum(rd_is_sum),
  .rd_unmapped(rd_unmapped)
);

// File: tb/tb_msi_term_collector.sv
module tb_msi_term_collector;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] irq;
  logic [15:0] err_cnt;

  msi_term_collector dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model [16][8];
  int err_exp = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  function automatic int ia(int g, int x); return g * 524288 + x * 65536; endfunction
  function automatic int sa(int g); return 8388608 + g * 65536; endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_irq();
    logic [15:0] m = '0;
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) if (model[g][x] != 0) m[g] = 1'b1;
    return m;
  endfunction

  // Driver: one cycle of stimulus, expected values computed from the requirements
  task automatic op(bit wv, int waddr, int wdata, bit rv, int raddr, string tag);
    logic [15:0] e;
    wr_valid = wv; wr_addr = waddr[23:0]; wr_data = wdata;
    rd_en = rv; rd_addr = raddr[23:0];
    if (rv) begin
      e = '0;
      if (raddr < 8388608 && raddr % 65536 == 0) begin
        e = model[raddr / 524288][(raddr / 65536) % 8];
        model[raddr / 524288][(raddr / 65536) % 8] = '0;
      end else if (raddr >= 8388608 && raddr % 65536 == 0 && (raddr - 8388608) / 65536 < 16) begin
        for (int x = 0; x < 8; x++) e[x] = (model[(raddr - 8388608) / 65536][x] != 0);
      end
      exp_q.push_back(e); tag_q.push_back(tag);
    end
    if (wv) begin
      if (waddr < 8388608 && waddr % 65536 == 0 && wdata >= 0 && wdata < 16)
        model[waddr / 524288][(waddr / 65536) % 8][wdata] = 1'b1;
      else if (err_exp < 65535) err_exp++;
    end
    @(negedge clk);
    wr_valid = 0; rd_en = 0;
  endtask

  task automatic wr(int a, int d); op(1, a, d, 0, 0, ""); endtask
  task automatic rd(int a, string tag); op(0, 0, 0, 1, a, tag); endtask

  task automatic chk_state(string tag);
    chk(irq, model_irq(), {tag, " irq"});
    chk(err_cnt, err_exp, {tag, " err_cnt"});
  endtask

  // Monitor: pops expected read data after the capturing edge
  always @(posedge clk) begin
    logic v;
    v = rd_en;
    #2;
    if (v && rst_n) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected read result, actual %0h expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) model[g][x] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R9 reset");
    rd(sa(0), "R9 reset summary");
    rd(ia(15, 7), "R9 reset index");

    // R1 / R3 / R4: single vector
    wr(ia(3, 5), 7);
    chk_state("R4 irq after write");
    rd(sa(3), "R3 summary g3");
    rd(ia(3, 5), "R2 read g3 i5");
    rd(ia(3, 5), "R2 cleared g3 i5");
    chk_state("R4 irq after clear");

    // R1: several bits, extremes 0 and 15, boundary group 15 index 7
    wr(ia(15, 7), 0);
    wr(ia(15, 7), 15);
    wr(ia(15, 7), 15);
    rd(ia(15, 7), "R1 bits 0 and 15 g15 i7");

    // R4: irq holds until every register of the group is clear
    wr(ia(0, 0), 1);
    wr(ia(0, 6), 2);
    rd(sa(0), "R3 summary two regs");
    rd(ia(0, 0), "R2 read g0 i0");
    chk_state("R4 irq holds with g0 i6 pending");
    rd(ia(0, 6), "R2 read g0 i6");
    chk_state("R4 irq drops");

    // R6: summary reads have no side effect
    wr(ia(9, 3), 4);
    rd(sa(9), "R6 summary first");
    rd(sa(9), "R6 summary second");
    chk_state("R6 state after summary reads");
    rd(ia(9, 3), "R6 index intact");

    // R5: same-cycle write and read on one register
    wr(ia(2, 1), 3);
    op(1, ia(2, 1), 9, 1, ia(2, 1), "R5 read returns old");
    chk_state("R5 irq stays");
    rd(ia(2, 1), "R5 new bit survives");
    op(1, ia(4, 2), 6, 1, ia(4, 2), "R5 empty reg read");
    rd(ia(4, 2), "R5 bit from empty case");
    // write and read to different registers at once
    wr(ia(7, 0), 11);
    op(1, ia(7, 1), 1, 1, ia(7, 0), "R2 read with other write");
    rd(ia(7, 1), "R1 other write landed");

    // R8: rejected writes
    wr(ia(5, 5), 16);
    chk_state("R8 data above 15");
    wr(sa(5), 2);
    chk_state("R8 summary offset write");
    wr(ia(5, 5) + 4, 2);
    chk_state("R8 low offset bits");
    rd(ia(5, 5), "R8 nothing pending g5 i5");
    rd(sa(5), "R8 summary g5 empty");

    // R7: unmapped reads
    wr(ia(6, 4), 5);
    rd(sa(16), "R7 summary beyond last group");
    rd(ia(6, 4) + 8, "R7 misaligned index");
    rd(24'hFFFFFF, "R7 top offset");
    chk_state("R7 state kept");
    rd(ia(6, 4), "R7 pending untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule